// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the hardware side of taking a processor exception. Every cycle it looks at seven request lines, the address presented on `cur_pc` and the current status word. It drops any interrupt request that the status word masks and picks the surviving request with the highest priority. It then issues, in one registered cycle, every register-file write that entry needs:

- the return address into the link register of the new mode;
- the old status word into the saved-status register of that mode;
- a rewritten current status word;
- the vector address into the program counter.

A single-cycle done pulse and a kind code go with these writes.

For synchronous exceptions (software interrupt, undefined instruction, prefetch abort, data abort), `cur_pc` is the address of the instruction that raised the exception. For the two interrupt requests, `cur_pc` is the address of the first instruction not yet executed. Returning from the handler is left to software.

Top module: `exc_entry_seq`

## Requirements
- R1: When a request survives masking in a cycle, the cycle after the next rising edge shows `entry_done`=1 together with every write strobe for that entry. With no surviving request, that cycle shows `entry_done`=0, every strobe and data output 0, and `entry_kind`=7.
- R2: Priority runs from highest to lowest: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. `entry_kind` gives the winner as 0 reset, 1 data abort, 2 FIQ, 3 IRQ, 4 prefetch abort, 5 undefined, 6 software interrupt.
- R3: Status bit 7 set discards `req_irq`, and status bit 6 set discards `req_fiq`. A lower-priority request that is present is then taken in their place.
- R4: For a software interrupt, an undefined instruction or a prefetch abort, `lr_data` is `cur_pc`+4.
- R5: For IRQ and FIQ, `lr_data` is `cur_pc`+4. For a data abort it is `cur_pc`+8. The addition wraps modulo 2^32.
- R6: For every kind except reset, `spsr_we`=1 and `spsr_data` equals the status word that was present with the request.
- R7: The mode code (status bits 4:0) goes on `lr_mode`, `spsr_mode` and `cpsr_data[4:0]`. The codes are: FIQ 10001, IRQ 10010, supervisor 10011 (reset and software interrupt), abort 10111 (both aborts) and undefined 11011.
- R8: The new status word is the old one with these changes: bit 7 set, bit 5 cleared, and bit 6 set for FIQ and reset but kept otherwise. Bits 31:8 are unchanged.
- R9: `pc_data` is the vector base (default 0) plus the offset for the kind: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R10: A reset-kind entry writes only the status word and the program counter. `lr_we` and `spsr_we` are 0, and `lr_data`, `lr_mode`, `spsr_data` and `spsr_mode` are 0.
- R11: `rst_n` low at a rising edge clears every output to its idle value (`entry_kind`=7). Requests present during that edge produce no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| cur_pc | input | 32 | Faulting or next-to-run instruction address |
| cur_psr | input | 32 | Current status word |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | 32 | Return address |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_mode | output | 5 | Mode whose saved-status register is written |
| spsr_data | output | 32 | Saved status word |
| cpsr_we | output | 1 | Current status write strobe |
| cpsr_data | output | 32 | New current status word |
| pc_we | output | 1 | Program counter write strobe |
| pc_data | output | 32 | Vector address |
| entry_done | output | 1 | One-cycle entry pulse |
| entry_kind | output | 3 | Kind taken, 7 when idle |

## Verification
Every result of this block falls due exactly one rising edge after the stimulus: the strobes, the data, the kind code and the done pulse. None is due earlier or later. The bench applies each stimulus at a falling edge and queues the expected entry, or the expected idle cycle. The monitor pops exactly one queued item per rising edge and samples 2 ns after that edge, so every comparison sees the registered result of the previous half-cycle's inputs. Reset behaviour is checked outside the queue, at the falling edge after the edge at which reset took effect.

// File: rtl/exc_pkg.sv
// Package: shared encodings for the exception entry sequencer.
// Assumes a status word whose low byte holds mode[4:0], T(5), F(6), I(7).
package exc_pkg;

    localparam int NUM_EXC = 7;
    localparam int PSR_T   = 5;
    localparam int PSR_F   = 6;
    localparam int PSR_I   = 7;
    localparam int MODE_W  = 5;

    // Kind codes double as priority index: lower value wins.
    typedef enum logic [2:0] {
        EXC_RST  = 3'd0,
        EXC_DABT = 3'd1,
        EXC_FIQ  = 3'd2,
        EXC_IRQ  = 3'd3,
        EXC_PABT = 3'd4,
        EXC_UND  = 3'd5,
        EXC_SWI  = 3'd6,
        EXC_NONE = 3'd7
    } exc_kind_e;

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

    // Mode entered for each exception kind.
    function automatic logic [MODE_W-1:0] mode_of(exc_kind_e k);
        case (k)
            EXC_FIQ:            mode_of = MODE_FIQ;
            EXC_IRQ:            mode_of = MODE_IRQ;
            EXC_DABT, EXC_PABT: mode_of = MODE_ABT;
            EXC_UND:            mode_of = MODE_UND;
            default:            mode_of = MODE_SVC;
        endcase
    endfunction

    // Byte offset of each kind's slot in the vector table.
    function automatic logic [7:0] vec_off(exc_kind_e k);
        case (k)
            EXC_RST:  vec_off = 8'h00;
            EXC_UND:  vec_off = 8'h04;
            EXC_SWI:  vec_off = 8'h08;
            EXC_PABT: vec_off = 8'h0C;
            EXC_DABT: vec_off = 8'h10;
            EXC_IRQ:  vec_off = 8'h18;
            EXC_FIQ:  vec_off = 8'h1C;
            default:  vec_off = 8'h00;
        endcase
    endfunction

    // Amount added to the presented address to form the return address.
    function automatic logic [3:0] ret_off(exc_kind_e k);
        ret_off = (k == EXC_DABT) ? 4'd8 : 4'd4;
    endfunction

    // Kinds that also raise the fast-interrupt mask.
    function automatic logic sets_fmask(exc_kind_e k);
        sets_fmask = (k == EXC_FIQ) || (k == EXC_RST);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Module: exc_arbiter
// Masks the two interrupt requests with the status I/F bits, then grants the
// surviving request with the lowest index (index = priority = kind code).
// Assumes req_raw is ordered as the kind codes in exc_pkg. Purely combinational;
// clk/rst_n are used only by the assertions.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N = NUM_EXC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_raw,
    input  logic         mask_irq,
    input  logic         mask_fiq,
    output logic         valid,
    output logic [N-1:0] grant,
    output exc_kind_e    kind
);

    logic [N-1:0] eligible;

    // Per-line qualification: only the IRQ and FIQ lines carry a mask.
    generate
        for (genvar g = 0; g < N; g++) begin : g_qual
            if (g == int'(EXC_IRQ)) begin : g_irq
                assign eligible[g] = req_raw[g] & ~mask_irq;
            end else if (g == int'(EXC_FIQ)) begin : g_fiq
                assign eligible[g] = req_raw[g] & ~mask_fiq;
            end else begin : g_plain
                assign eligible[g] = req_raw[g];
            end
        end
    endgenerate

    // Fixed-priority pick: scan high index to low so the lowest set index wins.
    always_comb begin
        grant = '0;
        kind  = EXC_NONE;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                kind     = exc_kind_e'(3'(i));
                valid    = 1'b1;
            end
        end
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_irq |-> !grant[int'(EXC_IRQ)]);

    // R3
    fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_fiq |-> !grant[int'(EXC_FIQ)]);

    // R2
    rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_raw[int'(EXC_RST)] |-> (kind == EXC_RST));

endmodule

// File: rtl/exc_link_calc.sv
// Module: exc_link_calc
// Forms the return address for the winning kind from the presented address.
// Assumes cur_pc is the faulting instruction (synchronous kinds) or the next
// unexecuted instruction (interrupts). Wraps modulo 2^ADDR_W.
module exc_link_calc
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  exc_kind_e           kind,
    input  logic [ADDR_W-1:0]   pc_in,
    output logic [ADDR_W-1:0]   link
);

    // Return address: +8 for data abort, +4 for all other kinds.
    always_comb begin
        link = pc_in + ADDR_W'(ret_off(kind));
    end

endmodule

// File: rtl/exc_psr_build.sv
// Module: exc_psr_build
// Builds the status word in force after entry: new mode, T cleared, I set,
// F set only for FIQ and reset. Assumes PSR_W >= 8.
module exc_psr_build
    import exc_pkg::*;
#(
    parameter int PSR_W = 32
) (
    input  exc_kind_e          kind,
    input  logic [PSR_W-1:0]   psr_in,
    output logic [PSR_W-1:0]   psr_out
);

    // Rewrite the control byte, leaving the upper status bits intact.
    always_comb begin
        psr_out                  = psr_in;
        psr_out[MODE_W-1:0]      = mode_of(kind);
        psr_out[PSR_T]           = 1'b0;
        psr_out[PSR_I]           = 1'b1;
        if (sets_fmask(kind)) begin
            psr_out[PSR_F] = 1'b1;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Module: exc_entry_seq (top)
// Picks one exception per cycle and commits all of its register-file writes
// together one clock later, with a one-cycle done pulse. Assumes the register
// file accepts the link, saved-status, status and PC writes in the same cycle.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter int               PSR_W    = 32,
    parameter logic [31:0]      VEC_BASE = 32'h0000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_rst,
    input  logic                req_dabt,
    input  logic                req_fiq,
    input  logic                req_irq,
    input  logic                req_pabt,
    input  logic                req_und,
    input  logic                req_swi,
    input  logic [ADDR_W-1:0]   cur_pc,
    input  logic [PSR_W-1:0]    cur_psr,
    output logic                lr_we,
    output logic [MODE_W-1:0]   lr_mode,
    output logic [ADDR_W-1:0]   lr_data,
    output logic                spsr_we,
    output logic [MODE_W-1:0]   spsr_mode,
    output logic [PSR_W-1:0]    spsr_data,
    output logic                cpsr_we,
    output logic [PSR_W-1:0]    cpsr_data,
    output logic                pc_we,
    output logic [ADDR_W-1:0]   pc_data,
    output logic                entry_done,
    output logic [2:0]          entry_kind
);

    localparam logic [ADDR_W-1:0] VBASE = ADDR_W'(VEC_BASE);

    logic [NUM_EXC-1:0] req_vec;
    logic               arb_valid;
    logic [NUM_EXC-1:0] arb_grant;
    exc_kind_e          arb_kind;
    logic [ADDR_W-1:0]  nxt_link;
    logic [PSR_W-1:0]   nxt_cpsr;
    logic [MODE_W-1:0]  nxt_mode;
    logic [ADDR_W-1:0]  nxt_vec;
    logic               nxt_saves;

    // Gather request lines in priority order (index = kind code).
    always_comb begin
        req_vec                 = '0;
        req_vec[int'(EXC_RST)]  = req_rst;
        req_vec[int'(EXC_DABT)] = req_dabt;
        req_vec[int'(EXC_FIQ)]  = req_fiq;
        req_vec[int'(EXC_IRQ)]  = req_irq;
        req_vec[int'(EXC_PABT)] = req_pabt;
        req_vec[int'(EXC_UND)]  = req_und;
        req_vec[int'(EXC_SWI)]  = req_swi;
    end

    exc_arbiter #(.N(NUM_EXC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_raw  (req_vec),
        .mask_irq (cur_psr[PSR_I]),
        .mask_fiq (cur_psr[PSR_F]),
        .valid    (arb_valid),
        .grant    (arb_grant),
        .kind     (arb_kind)
    );

    exc_link_calc #(.ADDR_W(ADDR_W)) u_link (
        .kind  (arb_kind),
        .pc_in (cur_pc),
        .link  (nxt_link)
    );

    exc_psr_build #(.PSR_W(PSR_W)) u_psr (
        .kind    (arb_kind),
        .psr_in  (cur_psr),
        .psr_out (nxt_cpsr)
    );

    // Mode, vector and save decision for the winning kind.
    always_comb begin
        nxt_mode  = mode_of(arb_kind);
        nxt_vec   = VBASE + ADDR_W'(vec_off(arb_kind));
        nxt_saves = arb_valid && (arb_kind != EXC_RST);
    end

    // Commit stage: all writes of one entry leave together; idle outputs are zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_we      <= 1'b0;
            lr_mode    <= '0;
            lr_data    <= '0;
            spsr_we    <= 1'b0;
            spsr_mode  <= '0;
            spsr_data  <= '0;
            cpsr_we    <= 1'b0;
            cpsr_data  <= '0;
            pc_we      <= 1'b0;
            pc_data    <= '0;
            entry_done <= 1'b0;
            entry_kind <= EXC_NONE;
        end else begin
            lr_we      <= nxt_saves;
            lr_mode    <= nxt_saves ? nxt_mode : '0;
            lr_data    <= nxt_saves ? nxt_link : '0;
            spsr_we    <= nxt_saves;
            spsr_mode  <= nxt_saves ? nxt_mode : '0;
            spsr_data  <= nxt_saves ? cur_psr : '0;
            cpsr_we    <= arb_valid;
            cpsr_data  <= arb_valid ? nxt_cpsr : '0;
            pc_we      <= arb_valid;
            pc_data    <= arb_valid ? nxt_vec : '0;
            entry_done <= arb_valid;
            entry_kind <= arb_valid ? arb_kind : EXC_NONE;
        end
    end

    // R1
    entry_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |=> (entry_done && cpsr_we && pc_we));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_valid |=> (!entry_done && !cpsr_we && !pc_we && !lr_we));

    // R6
    spsr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid && (arb_kind != EXC_RST) |=> (spsr_we && spsr_data == $past(cur_psr)));

    // R8
    imask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_we |-> (cpsr_data[PSR_I] && !cpsr_data[PSR_T]));

    // R7
    mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (lr_mode == cpsr_data[MODE_W-1:0] && spsr_mode == lr_mode));

    // R10
    rst_no_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done && entry_kind == 3'(EXC_RST)) |-> (!lr_we && !spsr_we));

endmodule

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reqs = '0;   // [0]rst [1]dabt [2]fiq [3]irq [4]pabt [5]und [6]swi
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psr = '0;
    logic        lr_we, spsr_we, cpsr_we, pc_we, entry_done;
    logic [4:0]  lr_mode, spsr_mode;
    logic [31:0] lr_data, spsr_data, cpsr_data, pc_data;
    logic [2:0]  entry_kind;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;
    bit ended = 1'b0;

    typedef struct {
        logic        done;
        logic [2:0]  kind;
        logic        lr_we;
        logic [4:0]  mode;
        logic [31:0] lr;
        logic        sp_we;
        logic [4:0]  sp_mode;
        logic [31:0] sp;
        logic [31:0] cpsr;
        logic [31:0] pc;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .req_rst(reqs[0]), .req_dabt(reqs[1]), .req_fiq(reqs[2]), .req_irq(reqs[3]),
        .req_pabt(reqs[4]), .req_und(reqs[5]), .req_swi(reqs[6]),
        .cur_pc(cur_pc), .cur_psr(cur_psr),
        .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data),
        .spsr_we(spsr_we), .spsr_mode(spsr_mode), .spsr_data(spsr_data),
        .cpsr_we(cpsr_we), .cpsr_data(cpsr_data),
        .pc_we(pc_we), .pc_data(pc_data),
        .entry_done(entry_done), .entry_kind(entry_kind)
    );

    // Reference model built from the requirements text.
    function automatic exp_t model(logic [6:0] r, logic [31:0] pc, logic [31:0] psr, string tag);
        exp_t e;
        logic [6:0] m;
        int k;
        logic [4:0] md;
        logic [31:0] vec;
        m = r;
        if (psr[7]) m[3] = 1'b0;
        if (psr[6]) m[2] = 1'b0;
        k = 7;
        for (int i = 6; i >= 0; i--) if (m[i]) k = i;
        e.tag = tag;
        e.done = 0; e.kind = 3'd7; e.lr_we = 0; e.mode = 0; e.lr = 0;
        e.sp_we = 0; e.sp_mode = 0; e.sp = 0; e.cpsr = 0; e.pc = 0;
        if (k == 7) return e;
        case (k)
            0: begin md = 5'b10011; vec = 32'h00; end
            1: begin md = 5'b10111; vec = 32'h10; end
            2: begin md = 5'b10001; vec = 32'h1C; end
            3: begin md = 5'b10010; vec = 32'h18; end
            4: begin md = 5'b10111; vec = 32'h0C; end
            5: begin md = 5'b11011; vec = 32'h04; end
            default: begin md = 5'b10011; vec = 32'h08; end
        endcase
        e.done = 1;
        e.kind = 3'(k);
        e.pc = vec;
        e.cpsr = {psr[31:8], 1'b1, (k == 0 || k == 2) ? 1'b1 : psr[6], 1'b0, md};
        if (k != 0) begin
            e.lr_we = 1; e.mode = md;
            e.lr = pc + ((k == 1) ? 32'd8 : 32'd4);
            e.sp_we = 1; e.sp_mode = md; e.sp = psr;
        end
        return e;
    endfunction

    // Driver: apply one cycle of stimulus at a falling edge and queue its expected result.
    task automatic drive(input logic [6:0] r, input logic [31:0] pc, input logic [31:0] psr, input string tag);
        @(negedge clk);
        reqs = r; cur_pc = pc; cur_psr = psr;
        q.push_back(model(r, pc, psr, tag));
    endtask

    // Monitor: one item is due per rising edge; sample 2 ns after it.
    always @(posedge clk) begin
        #2;
        if (mon_en && !ended) begin
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (entry_done !== e.done || entry_kind !== e.kind || lr_we !== e.lr_we ||
                    lr_mode !== e.mode || lr_data !== e.lr || spsr_we !== e.sp_we ||
                    spsr_mode !== e.sp_mode || spsr_data !== e.sp || cpsr_we !== e.done ||
                    cpsr_data !== e.cpsr || pc_we !== e.done || pc_data !== e.pc) begin
                    failures++;
                    $display("FAIL %s: got done=%b kind=%0d lr=%b/%b/%h spsr=%b/%b/%h cpsr=%b/%h pc=%b/%h exp done=%b kind=%0d lr=%b/%b/%h spsr=%b/%b/%h cpsr=%h pc=%h",
                        e.tag, entry_done, entry_kind, lr_we, lr_mode, lr_data, spsr_we, spsr_mode,
                        spsr_data, cpsr_we, cpsr_data, pc_we, pc_data, e.done, e.kind, e.lr_we,
                        e.mode, e.lr, e.sp_we, e.sp_mode, e.sp, e.cpsr, e.pc);
                end
            end else begin
                checks++;
                if (entry_done !== 1'b0) begin
                    failures++;
                    $display("FAIL R1: unexpected entry, got done=%b kind=%0d exp done=0", entry_done, entry_kind);
                end
            end
        end
    end

    // Reset-state check used by R11.
    task automatic check_idle(input string tag);
        checks++;
        if (entry_done !== 0 || lr_we !== 0 || spsr_we !== 0 || cpsr_we !== 0 || pc_we !== 0 ||
            entry_kind !== 3'd7 || cpsr_data !== 0 || pc_data !== 0 || lr_data !== 0) begin
            failures++;
            $display("FAIL %s: got done=%b we=%b%b%b%b kind=%0d cpsr=%h pc=%h lr=%h exp all zero, kind=7",
                tag, entry_done, lr_we, spsr_we, cpsr_we, pc_we, entry_kind, cpsr_data, pc_data, lr_data);
        end
    endtask

    initial begin
        // R11: requests held during reset produce nothing
        rst_n = 1'b0; reqs = 7'h7F; cur_pc = 32'h100; cur_psr = 32'h10;
        repeat (3) @(negedge clk);
        check_idle("R11 reset state");
        reqs = '0; rst_n = 1'b1; mon_en = 1'b1;

        drive(7'b1000000, 32'h0000_1000, 32'h0000_0010, "R4 R6 R7 R9 swi");
        drive(7'b0100000, 32'h0000_2004, 32'h6000_0010, "R4 R6 R7 R9 und");
        drive(7'b0010000, 32'h0000_3008, 32'h0000_001F, "R4 R7 R9 pabt");
        drive(7'b0001000, 32'h0000_400C, 32'h0000_0010, "R5 R8 irq keeps F");
        drive(7'b0000100, 32'h0000_5010, 32'h0000_0013, "R5 R8 fiq sets F");
        drive(7'b0000010, 32'h0000_6014, 32'h8000_0030, "R5 R8 dabt clears T");
        drive(7'b0000001, 32'h0000_7000, 32'hF000_0013, "R10 reset kind");
        drive(7'b0001000, 32'h0000_8000, 32'h0000_0090, "R3 irq masked");
        drive(7'b0000100, 32'h0000_8004, 32'h0000_0050, "R3 fiq masked");
        drive(7'b0001100, 32'h0000_8008, 32'h0000_0050, "R3 fiq masked irq taken");
        drive(7'b0011000, 32'h0000_800C, 32'h0000_0090, "R3 irq masked pabt taken");
        drive(7'b1111111, 32'h0000_9000, 32'h0000_0010, "R2 all lines");
        drive(7'b0000110, 32'h0000_9004, 32'h0000_0010, "R2 dabt over fiq");
        drive(7'b0001100, 32'h0000_9008, 32'h0000_0010, "R2 fiq over irq");
        drive(7'b0011000, 32'h0000_900C, 32'h0000_0010, "R2 irq over pabt");
        drive(7'b1110000, 32'h0000_9010, 32'h0000_0010, "R2 pabt over und");
        drive(7'b1100000, 32'h0000_9014, 32'h0000_0010, "R2 und over swi");
        drive(7'b0001000, 32'h0000_A000, 32'h2000_0050, "R8 irq with F kept set");
        drive(7'b0000000, 32'h0000_A004, 32'h0000_0010, "R1 idle");
        drive(7'b0000010, 32'hFFFF_FFFC, 32'h0000_0010, "R5 dabt wrap");
        drive(7'b0000100, 32'hFFFF_FFFC, 32'h0000_00B0, "R5 R8 fiq wrap thumb");
        drive(7'b0000000, 32'h0, 32'h0, "R1 idle tail");
        @(negedge clk);
        @(negedge clk);

        // R11: synchronous reset beats a pending request
        mon_en = 1'b0;
        rst_n = 1'b0; reqs = 7'b0001000; cur_psr = 32'h10; cur_pc = 32'h40;
        @(negedge clk);
        check_idle("R11 reset with request");
        rst_n = 1'b1; reqs = '0;
        @(negedge clk);
        check_idle("R11 after reset release");

        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            failures++;
            $display("FAIL R1: watchdog expired, got hang exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule